// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block turns a bus address that falls inside a graphics aperture into a system physical address. The top bits of the address's offset from the aperture base select one of 64 on-chip directory entries. Each entry names a 4 KB page of 1024 four-byte second-level entries in system memory, so each directory entry spans 4 MB of aperture. The next ten offset bits pick one second-level entry. The block reads that entry over a simple request/response memory port and joins its page address with the low twelve bits of the incoming address.

Software sets the block up through a small write-only configuration port. The directory is loaded one entry at a time through one packed word. Software also sets the aperture base and a size code. A four-entry translation cache avoids repeat memory reads, and software flushes it with a two-step control write. A lookup that misses the directory, hits an invalid second-level entry, or falls outside the aperture returns a fault response and sets a sticky fault bit. Software clears each fault bit by writing a one to it.

Top module: `aper_xlate`

## Requirements
- R1: The config select `cfg_sel_i` picks the target: 0 directory load, 1 aperture base (bits 31:22 of the data), 2 size code (bits 7:0), 3 control, 4 fault clear. A directory-load word uses bits 5:0 as the entry index, bit 8 as the present flag and bits 31:12 as the second-level page number. Bits 7:6 and 11:9 do not change translation.
- R2: A directory-load write with bit 8 clear makes that entry not present. Later uncached lookups through it fault as directory misses.
- R3: With offset = address - base, the directory index is offset bits 27:22 and the entry index is offset bits 21:12. A miss issues exactly one memory read at (page number × 4096 + entry index × 4), with the low two address bits zero. A good result is entry bits 31:12 joined with address bits 11:0.
- R4: The size code limits the number of usable directory entries: 0 gives 64, 32 gives 32, 48 gives 16 and 56 gives 8. Any other code gives none. An address below the base, or with offset bits 31:22 at or above that count, is a range fault and issues no memory read.
- R5: A fetched second-level entry with bit 0 clear produces a fault response and is not cached.
- R6: Four cached translations are held, with round-robin replacement. A lookup that hits issues no memory read.
- R7: A control write with bit 7 set flushes the cache only if the previous control write had bit 7 clear. The stored bit is clear after reset. A repeated bit-7-set write does not flush.
- R8: A flush that lands while a second-level fetch is outstanding stops the fetched entry from being cached. The lookup itself still completes with the fetched data.
- R9: `fault_o` holds sticky bits: bit 0 for a directory miss, bit 1 for an invalid second-level entry, bit 2 for a range fault. Writing select 4 with ones in bits 2:0 clears the matching bits only.
- R10: One lookup is in flight at a time. `req_ready_o` is high only when the block is idle, and a response stays valid and unchanged until `resp_ready_i` takes it.
- R11: After reset the block is idle with no response or memory request pending, `fault_o` is zero and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration target select |
| cfg_wdata_i | input | 32 | Configuration write data |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Block can accept a lookup |
| req_addr_i | input | 32 | Aperture bus address |
| resp_valid_o | output | 1 | Lookup response valid |
| resp_ready_i | input | 1 | Response consumer ready |
| resp_paddr_o | output | 32 | Translated physical address |
| resp_fault_o | output | 1 | Lookup faulted |
| mem_req_valid_o | output | 1 | Second-level read request |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_addr_o | output | 32 | Second-level entry address |
| mem_rsp_valid_i | input | 1 | Memory read data valid |
| mem_rsp_data_i | input | 32 | Second-level entry value |
| fault_o | output | 3 | Sticky fault bits |

## Verification
The hardest situation to reach from the ports is a flush that lands between the memory read request and its data. This is the only case where a fetched entry must be thrown away. The bench model of memory holds its answer for a set number of cycles, and the control writes are forked alongside the lookup so that both flush steps finish inside that window. Repeating the same address afterwards must then cost a fresh memory read, which the bench counts at the memory port. Round-robin eviction is shown the same way: five distinct pages are followed by a revisit of the evicted page and of one that should still be resident.

// File: rtl/aper_xlate_pkg.sv
package aper_xlate_pkg;

  localparam int AW       = 32;
  localparam int PAGE_W   = 20;
  localparam int PTE_IDX_W = 10;

  typedef enum logic [2:0] {
    CFG_DIR  = 3'd0,
    CFG_BASE = 3'd1,
    CFG_SIZE = 3'd2,
    CFG_CTRL = 3'd3,
    CFG_ERR  = 3'd4
  } cfg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } state_e;

  typedef struct packed {
    logic              present;
    logic [PAGE_W-1:0] page;
  } dir_ent_t;

  localparam int ERR_DIR   = 0;
  localparam int ERR_PTE   = 1;
  localparam int ERR_RANGE = 2;

  // size code -> usable directory entries
  function automatic logic [6:0] size_to_dirs(logic [7:0] code);
    case (code)
      8'd0:    return 7'd64;
      8'd32:   return 7'd32;
      8'd48:   return 7'd16;
      8'd56:   return 7'd8;
      default: return 7'd0;
    endcase
  endfunction

endpackage

// File: rtl/aper_cfg.sv
module aper_cfg
  import aper_xlate_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [2:0]  sel_i,
  input  logic [31:0] wdata_i,
  input  logic [2:0]  err_set_i,
  output logic [9:0]  base_o,
  output logic [6:0]  dirs_o,
  output logic        flush_o,
  output logic        dir_we_o,
  output logic [2:0]  err_o
);

  logic [9:0] base_q;
  logic [7:0] size_q;
  logic       ctrl_q;
  logic [2:0] err_q;
  logic [2:0] err_clr;

  assign dir_we_o = we_i && (sel_i == CFG_DIR);
  // flush on a bit-7 low-to-high step across control writes
  assign flush_o  = we_i && (sel_i == CFG_CTRL) && wdata_i[7] && !ctrl_q;
  assign err_clr  = (we_i && (sel_i == CFG_ERR)) ? wdata_i[2:0] : 3'b000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      size_q <= '0;
      ctrl_q <= 1'b0;
      err_q  <= '0;
    end else begin
      if (we_i && (sel_i == CFG_BASE)) base_q <= wdata_i[31:22];
      if (we_i && (sel_i == CFG_SIZE)) size_q <= wdata_i[7:0];
      if (we_i && (sel_i == CFG_CTRL)) ctrl_q <= wdata_i[7];
      err_q <= (err_q & ~err_clr) | err_set_i;
    end
  end

  assign base_o = base_q;
  assign dirs_o = size_to_dirs(size_q);
  assign err_o  = err_q;

endmodule

// File: rtl/aper_dir.sv
module aper_dir
  import aper_xlate_pkg::*;
#(
  parameter int N = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic          wr_present_i,
  input  logic [PAGE_W-1:0] wr_page_i,
  input  logic [IW-1:0] rd_idx_i,
  output dir_ent_t      rd_o
);

  dir_ent_t ent_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
    end else if (we_i) begin
      ent_q[wr_idx_i].present <= wr_present_i;
      ent_q[wr_idx_i].page    <= wr_page_i;
    end
  end

  assign rd_o = ent_q[rd_idx_i];

endmodule

// File: rtl/aper_tlb.sv
module aper_tlb #(
  parameter int N  = 4,
  parameter int TW = 16,
  parameter int PW = 20,
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [TW-1:0] tag_i,
  output logic          hit_o,
  output logic [PW-1:0] hit_page_o,
  input  logic          fill_i,
  input  logic [TW-1:0] fill_tag_i,
  input  logic [PW-1:0] fill_page_i
);

  logic [N-1:0]  valid_q;
  logic [TW-1:0] tag_q  [N];
  logic [PW-1:0] page_q [N];
  logic [PTR_W-1:0] ptr_q;
  logic [N-1:0]  match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == tag_i);
  end

  always_comb begin
    hit_page_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) hit_page_o = hit_page_o | page_q[i];
    end
  end
  assign hit_o = |match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ptr_q   <= '0;
      for (int i = 0; i < N; i++) begin
        tag_q[i]  <= '0;
        page_q[i] <= '0;
      end
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (fill_i) begin
      valid_q[ptr_q] <= 1'b1;
      tag_q[ptr_q]   <= fill_tag_i;
      page_q[ptr_q]  <= fill_page_i;
      ptr_q          <= (ptr_q == PTR_W'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/aper_xlate.sv
module aper_xlate
  import aper_xlate_pkg::*;
#(
  parameter int DIR_N = 64,
  parameter int TLB_N = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [2:0]  cfg_sel_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_addr_i,
  output logic        resp_valid_o,
  input  logic        resp_ready_i,
  output logic [31:0] resp_paddr_o,
  output logic        resp_fault_o,
  output logic        mem_req_valid_o,
  input  logic        mem_req_ready_i,
  output logic [31:0] mem_req_addr_o,
  input  logic        mem_rsp_valid_i,
  input  logic [31:0] mem_rsp_data_i,
  output logic [2:0]  fault_o
);

  localparam int DIR_W = $clog2(DIR_N);
  localparam int TAG_W = DIR_W + PTE_IDX_W;

  state_e      state_q;
  logic [31:0] addr_q;
  logic [31:0] memaddr_q;
  logic [31:0] paddr_q;
  logic        fault_q;
  logic        discard_q;

  logic [9:0]  base;
  logic [6:0]  dirs;
  logic        flush;
  logic        dir_we;
  logic [2:0]  err_set;

  logic [31:0] base_full;
  logic [31:0] off;
  logic        range_ok;
  logic [DIR_W-1:0]     dir_idx;
  logic [PTE_IDX_W-1:0] pte_idx;
  logic [TAG_W-1:0]     tag;
  dir_ent_t    dir_ent;
  logic        tlb_hit;
  logic [PAGE_W-1:0] tlb_page;
  logic        tlb_fill;
  logic        rsp_ok;

  aper_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .sel_i     (cfg_sel_i),
    .wdata_i   (cfg_wdata_i),
    .err_set_i (err_set),
    .base_o    (base),
    .dirs_o    (dirs),
    .flush_o   (flush),
    .dir_we_o  (dir_we),
    .err_o     (fault_o)
  );

  aper_dir #(.N(DIR_N)) u_dir (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (dir_we),
    .wr_idx_i     (cfg_wdata_i[DIR_W-1:0]),
    .wr_present_i (cfg_wdata_i[8]),
    .wr_page_i    (cfg_wdata_i[31:12]),
    .rd_idx_i     (dir_idx),
    .rd_o         (dir_ent)
  );

  aper_tlb #(.N(TLB_N), .TW(TAG_W), .PW(PAGE_W)) u_tlb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .tag_i       (tag),
    .hit_o       (tlb_hit),
    .hit_page_o  (tlb_page),
    .fill_i      (tlb_fill),
    .fill_tag_i  (tag),
    .fill_page_i (mem_rsp_data_i[31:12])
  );

  // address decomposition
  assign base_full = {base, 22'b0};
  assign off       = addr_q - base_full;
  assign range_ok  = (addr_q >= base_full) && (off[31:22] < {3'b000, dirs});
  assign dir_idx   = off[22 +: DIR_W];
  assign pte_idx   = off[21:12];
  assign tag       = off[12 +: TAG_W];

  assign rsp_ok   = mem_rsp_valid_i && mem_rsp_data_i[0];
  assign tlb_fill = (state_q == ST_WAIT) && rsp_ok && !discard_q && !flush;

  always_comb begin
    err_set = 3'b000;
    if (state_q == ST_CHECK) begin
      if (!range_ok)                       err_set[ERR_RANGE] = 1'b1;
      else if (!tlb_hit && !dir_ent.present) err_set[ERR_DIR] = 1'b1;
    end
    if ((state_q == ST_WAIT) && mem_rsp_valid_i && !mem_rsp_data_i[0])
      err_set[ERR_PTE] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      memaddr_q <= '0;
      paddr_q   <= '0;
      fault_q   <= 1'b0;
      discard_q <= 1'b0;
    end else begin
      if (flush && (state_q == ST_FETCH || state_q == ST_WAIT)) discard_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!range_ok) begin
            fault_q <= 1'b1;
            paddr_q <= '0;
            state_q <= ST_RESP;
          end else if (tlb_hit) begin
            fault_q <= 1'b0;
            paddr_q <= {tlb_page, addr_q[11:0]};
            state_q <= ST_RESP;
          end else if (!dir_ent.present) begin
            fault_q <= 1'b1;
            paddr_q <= '0;
            state_q <= ST_RESP;
          end else begin
            memaddr_q <= {dir_ent.page, pte_idx, 2'b00};
            discard_q <= 1'b0;
            state_q   <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          fault_q <= !mem_rsp_data_i[0];
          paddr_q <= mem_rsp_data_i[0] ? {mem_rsp_data_i[31:12], addr_q[11:0]} : '0;
          state_q <= ST_RESP;
        end
        ST_RESP: if (resp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign resp_valid_o    = (state_q == ST_RESP);
  assign resp_paddr_o    = paddr_q;
  assign resp_fault_o    = fault_q;
  assign mem_req_valid_o = (state_q == ST_FETCH);
  assign mem_req_addr_o  = memaddr_q;

endmodule

// File: rtl/aper_xlate_chk.sv
module aper_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_ready_o,
  input logic        resp_valid_o,
  input logic        resp_ready_i,
  input logic [31:0] resp_paddr_o,
  input logic        resp_fault_o,
  input logic        mem_req_valid_o,
  input logic        mem_req_ready_i,
  input logic [31:0] mem_req_addr_o,
  input logic [2:0]  fault_o
);

  assert_resp_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_ready_i) |=>
      (resp_valid_o && $stable(resp_paddr_o) && $stable(resp_fault_o)));

  assert_single_flight_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o || mem_req_valid_o) |-> !req_ready_o);

  assert_word_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_req_addr_o[1:0] == 2'b00));

  assert_mem_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o)));

  assert_fault_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(resp_valid_o) && resp_fault_o) |-> (fault_o != 3'b000));

endmodule

bind aper_xlate aper_xlate_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_ready_o     (req_ready_o),
  .resp_valid_o    (resp_valid_o),
  .resp_ready_i    (resp_ready_i),
  .resp_paddr_o    (resp_paddr_o),
  .resp_fault_o    (resp_fault_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .fault_o         (fault_o)
);

// File: tb/aper_xlate_bench.sv
module aper_xlate_bench;

  localparam logic [31:0] BASE = 32'h4000_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic        resp_valid_o;
  logic        resp_ready_i = 1'b1;
  logic [31:0] resp_paddr_o;
  logic        resp_fault_o;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b1;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic [2:0]  fault_o;

  int n_chk = 0;
  int n_fail = 0;
  int reads = 0;
  int rsp_delay = 0;
  logic [31:0] last_maddr = '0;
  logic        pend = 1'b0;
  int          cnt = 0;
  logic [31:0] pend_addr = '0;
  logic        done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  aper_xlate u_aper_xlate (.*);

  // memory model: entry at index 1023 reads zero, others map to
  // {4'h8, dir-page low bits, entry index, 12'h001}
  function automatic logic [31:0] mem_word(logic [31:0] a);
    if (a[11:2] == 10'h3FF) return 32'h0;
    return {4'h8, a[17:2], 12'h001};
  endfunction

  function automatic logic [31:0] exp_pa(logic [31:0] a);
    logic [31:0] o;
    o = a - BASE;
    return {4'h8, o[27:22], o[21:12], o[11:0]};
  endfunction

  always @(negedge clk_i) begin
    mem_rsp_valid_i <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid_i <= 1'b1;
        mem_rsp_data_i  <= mem_word(pend_addr);
        pend <= 1'b0;
      end else cnt <= cnt - 1;
    end else if (mem_req_valid_o && mem_req_ready_i) begin
      pend       <= 1'b1;
      cnt        <= rsp_delay;
      pend_addr  <= mem_req_addr_o;
      last_maddr <= mem_req_addr_o;
      reads      <= reads + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] a, output logic [31:0] pa, output logic flt);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int k = 0; k < 200 && !resp_valid_o; k++) @(negedge clk_i);
    pa = resp_paddr_o; flt = resp_fault_o;
  endtask

  task automatic load_dir(input int d);
    cfg_write(3'd0, {20'h00100 + 20'(d), 3'b000, 1'b1, 2'b00, 6'(d)});
  endtask

  task automatic flush_tlb();
    cfg_write(3'd3, 32'h2200);
    cfg_write(3'd3, 32'h2280);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // {address, expected fault kind: 0 none, 1 dir, 2 entry, 3 range}
  localparam logic [33:0] VEC [9] = '{
    {32'h4000_0123, 2'd0},
    {32'h4040_5ABC, 2'd0},
    {32'h4140_0FFF, 2'd0},
    {32'h4FC0_3004, 2'd0},
    {32'h41C0_0000, 2'd1},
    {32'h403F_F010, 2'd2},
    {32'h3FFF_FFFC, 2'd3},
    {32'h5000_0000, 2'd3},
    {32'h4000_0456, 2'd0}
  };

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      summary();
    end
  end

  initial begin
    logic [31:0] pa, pa0;
    logic flt;
    int r0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    chk(req_ready_o && !resp_valid_o && !mem_req_valid_o, "R11", {resp_valid_o, mem_req_valid_o}, 0);
    chk(fault_o == 3'b000, "R11", 32'(fault_o), 0);

    cfg_write(3'd1, BASE);
    cfg_write(3'd2, 32'd0);
    load_dir(0); load_dir(1); load_dir(63);
    // R1 attribute and reserved bits set: no effect on translation
    cfg_write(3'd0, {20'h00105, 3'b101, 1'b1, 2'b11, 6'd5});

    for (int i = 0; i < 9; i++) begin
      logic [31:0] a;
      logic [1:0]  kind;
      logic [2:0]  exp_f;
      a = VEC[i][33:2]; kind = VEC[i][1:0];
      exp_f = (kind == 2'd0) ? 3'b000 : (kind == 2'd1) ? 3'b001 : (kind == 2'd2) ? 3'b010 : 3'b100;
      cfg_write(3'd4, 32'h7);
      xlate(a, pa, flt);
      chk(flt == (kind != 2'd0), "R3/R4/R5 fault flag", 32'(flt), 32'(kind != 2'd0));
      if (kind == 2'd0) chk(pa == exp_pa(a), "R1/R3 paddr", pa, exp_pa(a));
      @(negedge clk_i);
      chk(fault_o == exp_f, "R9 sticky bits", 32'(fault_o), 32'(exp_f));
    end

    // R3 memory read address for a fresh miss
    xlate(32'h4040_A000, pa, flt);
    chk(last_maddr == 32'h0010_1028, "R3 mem addr", last_maddr, 32'h0010_1028);

    // R6 hit issues no read
    r0 = reads;
    xlate(32'h4040_A7FF, pa, flt);
    chk(reads == r0 && pa == 32'h8040_A7FF, "R6 hit", pa, 32'h8040_A7FF);

    // R6 round robin
    flush_tlb();
    r0 = reads;
    for (int k = 10; k < 15; k++) xlate(BASE + 32'(k) * 32'h1000, pa, flt);
    chk(reads == r0 + 5, "R6 fills", reads, r0 + 5);
    xlate(BASE + 32'h0000_A000, pa, flt);
    chk(reads == r0 + 6, "R6 evicted oldest", reads, r0 + 6);
    xlate(BASE + 32'h0000_C000, pa, flt);
    chk(reads == r0 + 6, "R6 survivor hits", reads, r0 + 6);

    // R7 repeated bit-7-set write does not flush, toggle does
    r0 = reads;
    cfg_write(3'd3, 32'h2280);
    xlate(BASE + 32'h0000_C000, pa, flt);
    chk(reads == r0, "R7 no flush", reads, r0);
    flush_tlb();
    xlate(BASE + 32'h0000_C000, pa, flt);
    chk(reads == r0 + 1, "R7 flush", reads, r0 + 1);

    // R8 flush while the fetch is outstanding
    flush_tlb();
    rsp_delay = 6;
    fork
      xlate(BASE + 32'h0001_4000, pa, flt);
      begin
        repeat (3) @(negedge clk_i);
        flush_tlb();
      end
    join
    rsp_delay = 0;
    chk(!flt && pa == exp_pa(BASE + 32'h0001_4000), "R8 result kept", pa, exp_pa(BASE + 32'h0001_4000));
    r0 = reads;
    xlate(BASE + 32'h0001_4000, pa, flt);
    chk(reads == r0 + 1, "R8 discarded", reads, r0 + 1);

    // R2 invalidate directory entry 1
    cfg_write(3'd0, 32'h0000_0001);
    cfg_write(3'd4, 32'h7);
    xlate(32'h4040_7000, pa, flt);
    @(negedge clk_i);
    chk(flt && fault_o == 3'b001, "R2 invalidated", 32'(fault_o), 32'h1);

    // R4 size codes
    cfg_write(3'd2, 32'd56);
    xlate(32'h4140_0000, pa, flt);
    chk(!flt, "R4 size 56 in", 32'(flt), 0);
    r0 = reads;
    xlate(32'h4200_0000, pa, flt);
    chk(flt && reads == r0, "R4 size 56 out", 32'(flt), 1);
    cfg_write(3'd2, 32'd48);
    cfg_write(3'd4, 32'h7);
    xlate(32'h43C0_0000, pa, flt);
    @(negedge clk_i);
    chk(fault_o == 3'b001, "R4 size 48 last entry", 32'(fault_o), 32'h1);
    xlate(32'h4400_0000, pa, flt);
    @(negedge clk_i);
    chk(fault_o == 3'b101, "R4 size 48 out", 32'(fault_o), 32'h5);
    // R9 partial clear
    cfg_write(3'd4, 32'h1);
    chk(fault_o == 3'b100, "R9 clear bit0 only", 32'(fault_o), 32'h4);
    cfg_write(3'd4, 32'h4);
    chk(fault_o == 3'b000, "R9 clear bit2", 32'(fault_o), 32'h0);
    cfg_write(3'd2, 32'd32);
    xlate(32'h47C0_0000, pa, flt);
    @(negedge clk_i);
    chk(fault_o == 3'b001, "R4 size 32 last entry", 32'(fault_o), 32'h1);
    xlate(32'h4800_0000, pa, flt);
    @(negedge clk_i);
    chk(fault_o == 3'b101, "R4 size 32 out", 32'(fault_o), 32'h5);
    cfg_write(3'd2, 32'd7);
    xlate(32'h4000_0000, pa, flt);
    chk(flt, "R4 unknown code", 32'(flt), 1);
    cfg_write(3'd2, 32'd0);

    // R10 backpressure
    resp_ready_i = 1'b0;
    xlate(32'h4000_0777, pa0, flt);
    repeat (3) @(negedge clk_i);
    chk(resp_valid_o && resp_paddr_o == pa0 && !req_ready_o, "R10 hold", resp_paddr_o, pa0);
    chk(pa0 == exp_pa(32'h4000_0777), "R10 value", pa0, exp_pa(32'h4000_0777));
    resp_ready_i = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !resp_valid_o, "R10 release", 32'(req_ready_o), 1);

    done = 1'b1;
    summary();
  end

endmodule